// File: doc/BRIEF.md
# Prior-Result Branch and Subroutine Unit

This block carries out the non-register instructions of a small 16-bit pseudo-processor that keeps sixteen 16-bit registers. It does not store condition flags as separate bits. Instead it keeps one "prior result" byte. Bits 4:1 of that byte hold the number of the register that the last register instruction produced. Bit 0 holds the carry that the instruction left. A branch reads that register again through the register-file read port, tests the value against its condition, and produces the next program counter.

Two instructions use a return stack in byte memory, with register 12 as the stack pointer:
- Branch-to-subroutine pushes the return address and then branches.
- Return-from-subroutine pops the return address back into the program counter.

The surrounding core presents one non-register instruction at a time on the operation inputs. It supplies the address of the opcode byte and the displacement byte. It also reports every completed register instruction on the update inputs. The block answers with a one-cycle `done`, the next program counter and, for stack operations, a write of register 12.

Top module: `prior_branch_unit`

## Requirements
- R1: A register-instruction update stores its result register as the prior index. For opcodes A (add) and B (subtract) the index is 0, for opcode D (compare) it is 13, and for every other opcode it is `updReg`. While idle and no stack operation is offered, `rdIdx` shows this index.
- R2: Bit 0 of the prior byte takes `updCarry` for opcodes A, B and D. For every other opcode it is cleared, whatever `updCarry` is.
- R3: Opcode 1 always branches, opcode 2 branches when the carry is clear and opcode 3 branches when the carry is set.
- R4: Opcode 4 branches when bit 15 of the prior register is 0. Opcode 5 branches when that bit is 1.
- R5: Opcode 6 branches when the prior register is 0000 and opcode 7 when it is not. Opcode 8 branches when it is FFFF and opcode 9 when it is not.
- R6: A taken branch gives `opPc + 2 + sign-extended opDisp`, modulo 2^16. A branch that is not taken gives `opPc + 2`. `done` and `pcNext` appear in the cycle after the operation is accepted.
- R7: A branch, taken or not, leaves the prior byte unchanged.
- R8: Opcode C writes the low byte of `opPc + 2` to address R12, then the high byte to R12+1. It then writes R12+2 into register 12 and sets `pcNext` to the branch target. The register write and `done` occur in the same cycle.
- R9: Opcode B reads the high byte from R12-1 and then the low byte from R12-2. It writes R12-2 into register 12 and sets `pcNext` to the popped address.
- R10: Opcodes D, E and F give `pcNext = opPc + 2`. Opcodes 0 and A give `opPc + 1`. None of these opcodes accesses memory or writes a register.
- R11: `memReq` stays high with a stable address, write enable and write data until `memReady` is sampled high. There is no memory request while the block is idle.
- R12: After reset, `done`, `memReq`, `regWe` and `busy` are low and the prior byte is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | A register instruction completed this cycle |
| updOp | input | 4 | Opcode nibble of that register instruction |
| updReg | input | 4 | Register field of that register instruction |
| updCarry | input | 1 | Carry produced by that instruction |
| opValid | input | 1 | Non-register operation offered (taken when `busy` is low) |
| opCode | input | 4 | Non-register opcode |
| opDisp | input | 8 | Signed displacement byte |
| opPc | input | 16 | Address of the opcode byte |
| rdIdx | output | 4 | Register-file read index |
| rdData | input | 16 | Register-file read data for `rdIdx` |
| busy | output | 1 | Stack operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pcNext | output | 16 | Next program counter, valid with `done` |
| regWe | output | 1 | Register write strobe |
| regWIdx | output | 4 | Register write index (always 12) |
| regWData | output | 16 | Register write data |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write when high, read when low |
| memAddr | output | 16 | Memory byte address |
| memWData | output | 8 | Memory write data |
| memRData | input | 8 | Memory read data, valid with `memReady` |
| memReady | input | 1 | Memory completes the request at this edge |

## Verification
The assertions assume three things about the inputs:
- Operations are offered only while `busy` is low.
- `memReady` rises only against a pending request.
- No register update arrives while a stack operation is in flight.

The bench keeps to all three. Its tasks wait for idle before they drive `opValid`. Its memory model counts a programmable latency only while `memReq` is high. Register updates are issued only between operations. Within those limits the stimulus covers every branch condition on both outcomes and the displacement extremes. It also runs push and pop with zero and nonzero memory latency.

// File: rtl/pbu_pkg.sv
package pbu_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_LO,
    S_PUSH_HI,
    S_POP_HI,
    S_POP_LO
  } state_e;

  typedef struct packed {
    logic selStackRd;
    logic loadBranch;
    logic loadStack;
    logic spInc;
    logic spDec;
    logic grabHi;
    logic selHi;
    logic finishPush;
    logic finishPop;
  } strobe_t;

  // non-register opcodes
  localparam logic [3:0] OP_RTN  = 4'h0;
  localparam logic [3:0] OP_BR   = 4'h1;
  localparam logic [3:0] OP_BNC  = 4'h2;
  localparam logic [3:0] OP_BC   = 4'h3;
  localparam logic [3:0] OP_BP   = 4'h4;
  localparam logic [3:0] OP_BM   = 4'h5;
  localparam logic [3:0] OP_BZ   = 4'h6;
  localparam logic [3:0] OP_BNZ  = 4'h7;
  localparam logic [3:0] OP_BM1  = 4'h8;
  localparam logic [3:0] OP_BNM1 = 4'h9;
  localparam logic [3:0] OP_BK   = 4'hA;
  localparam logic [3:0] OP_RS   = 4'hB;
  localparam logic [3:0] OP_BS   = 4'hC;

  // register opcodes that redirect the prior index
  localparam logic [3:0] RG_ADD = 4'hA;
  localparam logic [3:0] RG_SUB = 4'hB;
  localparam logic [3:0] RG_CPR = 4'hD;

endpackage

// File: rtl/pbu_datapath.sv
module pbu_datapath
  import pbu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 4,
  parameter int SP_IDX  = 12,
  parameter int CMP_IDX = 13,
  parameter int ACC_IDX = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic                  updValid,
  input  logic [3:0]            updOp,
  input  logic [IDX_W-1:0]      updReg,
  input  logic                  updCarry,
  input  logic [3:0]            opCode,
  input  logic [DATA_W/2-1:0]   opDisp,
  input  logic [DATA_W-1:0]     opPc,
  input  logic [DATA_W-1:0]     rdData,
  input  logic [DATA_W/2-1:0]   memRData,
  output logic [IDX_W-1:0]      rdIdx,
  output logic [DATA_W-1:0]     memAddr,
  output logic [DATA_W/2-1:0]   memWData,
  output logic [DATA_W-1:0]     pcNext,
  output logic [DATA_W-1:0]     regWData
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W - BYTE_W;

  logic [IDX_W:0]      prior;
  logic [DATA_W-1:0]   sp, retPc, tgtPc, pcNextR, regWDataR;
  logic [BYTE_W-1:0]   hiByte;
  logic [DATA_W-1:0]   dispExt, seqPc, target, branchPc;
  logic                taken, carryBit, isNeg, isZero, isAllOnes;

  // prior-result byte: doubled register index with carry in bit 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prior <= '0;
    end else if (updValid) begin
      unique case (updOp)
        RG_ADD, RG_SUB: prior <= {IDX_W'(ACC_IDX), updCarry};
        RG_CPR:         prior <= {IDX_W'(CMP_IDX), updCarry};
        default:        prior <= {updReg, 1'b0};
      endcase
    end
  end

  // branch condition on the re-read prior register
  always_comb begin
    carryBit  = prior[0];
    isNeg     = rdData[DATA_W-1];
    isZero    = ~|rdData;
    isAllOnes = &rdData;
    unique case (opCode)
      OP_BR, OP_BS: taken = 1'b1;
      OP_BNC:       taken = ~carryBit;
      OP_BC:        taken = carryBit;
      OP_BP:        taken = ~isNeg;
      OP_BM:        taken = isNeg;
      OP_BZ:        taken = isZero;
      OP_BNZ:       taken = ~isZero;
      OP_BM1:       taken = isAllOnes;
      OP_BNM1:      taken = ~isAllOnes;
      default:      taken = 1'b0;
    endcase
  end

  always_comb begin
    dispExt = {{EXT_W{opDisp[BYTE_W-1]}}, opDisp};
    seqPc   = opPc + DATA_W'(2);
    target  = seqPc + dispExt;
    if (opCode == OP_RTN || opCode == OP_BK) branchPc = opPc + DATA_W'(1);
    else if (taken)                          branchPc = target;
    else                                     branchPc = seqPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp        <= '0;
      retPc     <= '0;
      tgtPc     <= '0;
      hiByte    <= '0;
      pcNextR   <= '0;
      regWDataR <= '0;
    end else begin
      if (stb.loadBranch) pcNextR <= branchPc;
      if (stb.loadStack) begin
        sp    <= (opCode == OP_RS) ? rdData - DATA_W'(1) : rdData;
        retPc <= seqPc;
        tgtPc <= target;
      end
      if (stb.spInc)  sp <= sp + DATA_W'(1);
      if (stb.spDec)  sp <= sp - DATA_W'(1);
      if (stb.grabHi) hiByte <= memRData;
      if (stb.finishPush) begin
        pcNextR   <= tgtPc;
        regWDataR <= sp + DATA_W'(1);
      end
      if (stb.finishPop) begin
        pcNextR   <= {hiByte, memRData};
        regWDataR <= sp;
      end
    end
  end

  assign rdIdx    = stb.selStackRd ? IDX_W'(SP_IDX) : prior[IDX_W:1];
  assign memAddr  = sp;
  assign memWData = stb.selHi ? retPc[DATA_W-1:BYTE_W] : retPc[BYTE_W-1:0];
  assign pcNext   = pcNextR;
  assign regWData = regWDataR;

endmodule

// File: rtl/pbu_control.sv
module pbu_control
  import pbu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic       memReady,
  output strobe_t    stb,
  output logic       busy,
  output logic       memReq,
  output logic       memWe,
  output logic       done,
  output logic       regWe
);

  state_e state, stateNext;
  logic   doneNext, regWeNext;
  logic   isPush, isPop;

  assign isPush = (opCode == OP_BS);
  assign isPop  = (opCode == OP_RS);

  always_comb begin
    stb       = '0;
    stateNext = state;
    doneNext  = 1'b0;
    regWeNext = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      S_IDLE: begin
        stb.selStackRd = opValid && (isPush || isPop);
        if (opValid) begin
          if (isPush) begin
            stb.loadStack = 1'b1;
            stateNext     = S_PUSH_LO;
          end else if (isPop) begin
            stb.loadStack = 1'b1;
            stateNext     = S_POP_HI;
          end else begin
            stb.loadBranch = 1'b1;
            doneNext       = 1'b1;
          end
        end
      end
      S_PUSH_LO: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          stb.spInc = 1'b1;
          stateNext = S_PUSH_HI;
        end
      end
      S_PUSH_HI: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        stb.selHi = 1'b1;
        if (memReady) begin
          stb.finishPush = 1'b1;
          doneNext       = 1'b1;
          regWeNext      = 1'b1;
          stateNext      = S_IDLE;
        end
      end
      S_POP_HI: begin
        memReq = 1'b1;
        if (memReady) begin
          stb.grabHi = 1'b1;
          stb.spDec  = 1'b1;
          stateNext  = S_POP_LO;
        end
      end
      S_POP_LO: begin
        memReq = 1'b1;
        if (memReady) begin
          stb.finishPop = 1'b1;
          doneNext      = 1'b1;
          regWeNext     = 1'b1;
          stateNext     = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      regWe <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      regWe <= regWeNext;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/prior_branch_unit.sv
module prior_branch_unit
  import pbu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 4,
  parameter int SP_IDX  = 12,
  parameter int CMP_IDX = 13,
  parameter int ACC_IDX = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                updValid,
  input  logic [3:0]          updOp,
  input  logic [IDX_W-1:0]    updReg,
  input  logic                updCarry,
  input  logic                opValid,
  input  logic [3:0]          opCode,
  input  logic [DATA_W/2-1:0] opDisp,
  input  logic [DATA_W-1:0]   opPc,
  output logic [IDX_W-1:0]    rdIdx,
  input  logic [DATA_W-1:0]   rdData,
  output logic                busy,
  output logic                done,
  output logic [DATA_W-1:0]   pcNext,
  output logic                regWe,
  output logic [IDX_W-1:0]    regWIdx,
  output logic [DATA_W-1:0]   regWData,
  output logic                memReq,
  output logic                memWe,
  output logic [DATA_W-1:0]   memAddr,
  output logic [DATA_W/2-1:0] memWData,
  input  logic [DATA_W/2-1:0] memRData,
  input  logic                memReady
);

  strobe_t stb;

  pbu_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opCode   (opCode),
    .memReady (memReady),
    .stb      (stb),
    .busy     (busy),
    .memReq   (memReq),
    .memWe    (memWe),
    .done     (done),
    .regWe    (regWe)
  );

  pbu_datapath #(
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .SP_IDX  (SP_IDX),
    .CMP_IDX (CMP_IDX),
    .ACC_IDX (ACC_IDX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .updValid (updValid),
    .updOp    (updOp),
    .updReg   (updReg),
    .updCarry (updCarry),
    .opCode   (opCode),
    .opDisp   (opDisp),
    .opPc     (opPc),
    .rdData   (rdData),
    .memRData (memRData),
    .rdIdx    (rdIdx),
    .memAddr  (memAddr),
    .memWData (memWData),
    .pcNext   (pcNext),
    .regWData (regWData)
  );

  assign regWIdx = IDX_W'(SP_IDX);

endmodule

// File: rtl/pbu_checker.sv
module pbu_checker #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                opValid,
  input logic [3:0]          opCode,
  input logic [DATA_W/2-1:0] opDisp,
  input logic [DATA_W-1:0]   opPc,
  input logic                busy,
  input logic                done,
  input logic [DATA_W-1:0]   pcNext,
  input logic                regWe,
  input logic [IDX_W-1:0]    regWIdx,
  input logic                memReq,
  input logic                memWe,
  input logic [DATA_W-1:0]   memAddr,
  input logic [DATA_W/2-1:0] memWData,
  input logic                memReady
);

  localparam int BYTE_W = DATA_W / 2;

  a_r11_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWData)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  a_r8_regwrite_with_done: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (done && regWIdx == IDX_W'(12)));

  a_r6_branch_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy && opCode != 4'hB && opCode != 4'hC) |=> (done && !busy && !regWe));

  a_r6_always_target: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy && opCode == 4'h1) |=>
      (pcNext == $past(opPc) + DATA_W'(2) +
                 {{(DATA_W-BYTE_W){$past(opDisp[BYTE_W-1])}}, $past(opDisp)}));

  a_r9_pop_starts_read: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy && opCode == 4'hB) |=> (busy && memReq && !memWe));

  a_r8_push_starts_write: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy && opCode == 4'hC) |=> (busy && memReq && memWe));

endmodule

bind prior_branch_unit pbu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_prior_branch_unit.sv
module tb_prior_branch_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        updValid, updCarry, opValid;
  logic [3:0]  updOp, updReg, opCode, rdIdx, regWIdx;
  logic [7:0]  opDisp, memWData, memRData;
  logic [15:0] opPc, rdData, pcNext, regWData, memAddr;
  logic        busy, done, regWe, memReq, memWe, memReady;

  always #4 clk = ~clk;

  prior_branch_unit dut (.*);

  // behavioural register file and byte memory
  logic [15:0] regs [16];
  logic [7:0]  mem  [256];
  logic [23:0] wrLog[$];
  logic [15:0] rdLog[$];
  int          lag = 0;
  int          waitCnt = 0;

  assign rdData   = regs[rdIdx];
  assign memReady = memReq && (waitCnt >= lag);
  assign memRData = mem[memAddr[7:0]];

  always @(posedge clk) begin
    if (memReq && !memReady) waitCnt <= waitCnt + 1;
    else                     waitCnt <= 0;
    if (memReq && memReady) begin
      if (memWe) begin
        mem[memAddr[7:0]] <= memWData;
        wrLog.push_back({memAddr, memWData});
      end else begin
        rdLog.push_back(memAddr);
      end
    end
    if (regWe) regs[regWIdx] <= regWData;
  end

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;
  bit stackOn = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tgt(input logic [15:0] pc, input logic [7:0] d);
    int v;
    v = int'(pc) + 2 + int'($signed(d));
    return v[15:0];
  endfunction

  // every-clock comparison against the stack-activity model
  logic        prevWait = 0;
  logic [15:0] prevAddr = '0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(!(regWe && !done), "R8 regWe without done", regWe, 0);
      check(!(memReq && !stackOn), "R11 request outside stack op", memReq, 0);
      if (prevWait) check(memReq && memAddr == prevAddr, "R11 request held", memAddr, prevAddr);
      prevWait = memReq && !memReady;
      prevAddr = memAddr;
    end
  end

  task automatic upd(input logic [3:0] op, input logic [3:0] rg, input bit cy,
                     input logic [3:0] resIdx, input logic [15:0] val, input logic [3:0] expIdx,
                     input string req);
    @(negedge clk);
    regs[resIdx] <= val;
    updValid = 1; updOp = op; updReg = rg; updCarry = cy;
    @(negedge clk);
    updValid = 0;
    check(rdIdx == expIdx, req, rdIdx, expIdx);
  endtask

  task automatic branch(input logic [3:0] code, input logic [7:0] d, input logic [15:0] pc,
                        input logic [15:0] expPc, input string req);
    @(negedge clk);
    while (busy) @(negedge clk);
    opValid = 1; opCode = code; opDisp = d; opPc = pc;
    @(negedge clk);
    opValid = 0;
    check(done === 1'b1, req, done, 1);
    check(pcNext == expPc, req, pcNext, expPc);
    check(regWe === 1'b0, req, regWe, 0);
  endtask

  task automatic stackOp(input logic [3:0] code, input logic [7:0] d, input logic [15:0] pc,
                         input logic [15:0] expPc, input logic [15:0] expSp, input string req);
    int n;
    @(negedge clk);
    while (busy) @(negedge clk);
    stackOn = 1;
    opValid = 1; opCode = code; opDisp = d; opPc = pc;
    @(negedge clk);
    opValid = 0;
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    check(done === 1'b1, req, done, 1);
    check(pcNext == expPc, req, pcNext, expPc);
    check(regWe === 1'b1 && regWIdx == 4'd12, req, {regWe, regWIdx}, 5'h1C);
    check(regWData == expSp, req, regWData, expSp);
    @(negedge clk);
    stackOn = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    rstN = 0; updValid = 0; updOp = 0; updReg = 0; updCarry = 0;
    opValid = 0; opCode = 0; opDisp = 0; opPc = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12: reset state
    check(done === 0 && memReq === 0 && regWe === 0 && busy === 0, "R12 outputs", {done, memReq, regWe, busy}, 0);
    check(rdIdx == 0, "R12 prior zero", rdIdx, 0);

    // R4: sign tests on R5 = 8000
    upd(4'h2, 4'd5, 0, 4'd5, 16'h8000, 4'd5, "R1 plain index");
    branch(4'h4, 8'h10, 16'h0200, 16'h0202, "R4 BP not taken");
    branch(4'h5, 8'h10, 16'h0200, tgt(16'h0200, 8'h10), "R4 BM taken");

    // R5: zero tests
    upd(4'hE, 4'd3, 0, 4'd3, 16'h0000, 4'd3, "R1 index 3");
    branch(4'h6, 8'hF0, 16'h0400, tgt(16'h0400, 8'hF0), "R5 BZ taken");
    branch(4'h7, 8'hF0, 16'h0400, 16'h0402, "R5 BNZ not taken");

    // R5: minus-one tests
    upd(4'hF, 4'd4, 0, 4'd4, 16'hFFFF, 4'd4, "R1 index 4");
    branch(4'h8, 8'h05, 16'h0600, tgt(16'h0600, 8'h05), "R5 BM1 taken");
    branch(4'h9, 8'h05, 16'h0600, 16'h0602, "R5 BNM1 not taken");
    branch(4'h4, 8'h05, 16'h0600, 16'h0602, "R4 BP on FFFF");
    upd(4'hE, 4'd4, 0, 4'd4, 16'h00FF, 4'd4, "R1 index 4 again");
    branch(4'h8, 8'h05, 16'h0600, 16'h0602, "R5 BM1 on 00FF");
    branch(4'h9, 8'h05, 16'h0600, tgt(16'h0600, 8'h05), "R5 BNM1 on 00FF");

    // R1/R2/R3: add selects R0 and keeps carry
    upd(4'hA, 4'd7, 1, 4'd0, 16'h70B6, 4'd0, "R1 add selects R0");
    branch(4'h3, 8'h20, 16'h0800, tgt(16'h0800, 8'h20), "R3 BC taken");
    branch(4'h2, 8'h20, 16'h0800, 16'h0802, "R3 BNC not taken");
    branch(4'h4, 8'h20, 16'h0800, tgt(16'h0800, 8'h20), "R4 BP positive");
    // R7: conditions survive branches
    branch(4'h3, 8'h20, 16'h0900, tgt(16'h0900, 8'h20), "R7 BC repeat");
    check(rdIdx == 0, "R7 prior index kept", rdIdx, 0);

    // compare selects R13
    upd(4'hD, 4'd6, 0, 4'd13, 16'h1234, 4'd13, "R1 compare selects R13");
    branch(4'h2, 8'h08, 16'h0A00, tgt(16'h0A00, 8'h08), "R3 BNC taken");
    branch(4'h3, 8'h08, 16'h0A00, 16'h0A02, "R3 BC not taken");

    // R2: carry dropped for non-arithmetic opcodes
    upd(4'h1, 4'd2, 1, 4'd2, 16'h0005, 4'd2, "R1 set index 2");
    branch(4'h3, 8'h08, 16'h0B00, 16'h0B02, "R2 carry cleared BC");
    branch(4'h2, 8'h08, 16'h0B00, tgt(16'h0B00, 8'h08), "R2 carry cleared BNC");
    upd(4'hB, 4'd9, 0, 4'd0, 16'h0000, 4'd0, "R1 sub selects R0");
    branch(4'h6, 8'h02, 16'h0C00, tgt(16'h0C00, 8'h02), "R5 BZ after sub");

    // R6: displacement extremes and wrap
    branch(4'h1, 8'h80, 16'h1000, 16'h0F82, "R6 BR -128");
    branch(4'h1, 8'h7F, 16'h1000, 16'h1081, "R6 BR +127");
    branch(4'h1, 8'h20, 16'hFFF0, 16'h0012, "R6 BR wrap");

    // R10: unassigned and one-byte opcodes
    branch(4'hD, 8'h33, 16'h0500, 16'h0502, "R10 op D");
    branch(4'hE, 8'h33, 16'h0500, 16'h0502, "R10 op E");
    branch(4'hF, 8'h33, 16'h0500, 16'h0502, "R10 op F");
    branch(4'h0, 8'h33, 16'h0500, 16'h0501, "R10 op 0");
    branch(4'hA, 8'h33, 16'h0500, 16'h0501, "R10 op A");

    // R8: push with slow memory
    @(negedge clk); regs[12] <= 16'h0040; lag = 2;
    wrLog.delete(); rdLog.delete();
    stackOp(4'hC, 8'h10, 16'h0300, 16'h0312, 16'h0042, "R8 BS");
    check(wrLog.size() == 2, "R8 write count", wrLog.size(), 2);
    if (wrLog.size() == 2) begin
      check(wrLog[0] == 24'h004002, "R8 low byte first", wrLog[0], 24'h004002);
      check(wrLog[1] == 24'h004103, "R8 high byte second", wrLog[1], 24'h004103);
    end

    // R9: pop with fast memory
    lag = 0;
    stackOp(4'hB, 8'h00, 16'h0700, 16'h0302, 16'h0040, "R9 RS");
    check(rdLog.size() == 2, "R9 read count", rdLog.size(), 2);
    if (rdLog.size() == 2) begin
      check(rdLog[0] == 16'h0041, "R9 high first", rdLog[0], 16'h0041);
      check(rdLog[1] == 16'h0040, "R9 low second", rdLog[1], 16'h0040);
    end

    // second pair: push fast, pop slow, backward branch
    @(negedge clk); regs[12] <= 16'h0080;
    wrLog.delete(); rdLog.delete();
    stackOp(4'hC, 8'hF0, 16'h0FF0, 16'h0FE2, 16'h0082, "R8 BS backward");
    if (wrLog.size() == 2)
      check(wrLog[0] == 24'h0080F2 && wrLog[1] == 24'h00810F, "R8 pushed bytes", wrLog[1], 24'h00810F);
    else
      check(0, "R8 pushed bytes", wrLog.size(), 2);
    lag = 3;
    stackOp(4'hB, 8'h00, 16'h0FE2, 16'h0FF2, 16'h0080, "R9 RS slow");
    check(rdIdx == 0, "R7 prior after stack ops", rdIdx, 0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nCmp++; nBad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule